// File: doc/BRIEF.md
# Flash Sector Erase Engine with Pause Support

This block models the command and status side of a parallel NOR flash erase engine. It takes already-decoded commands on a synchronous command port. It keeps a record of the sectors chosen for erasure and runs a cycle-counted erase timer. For every read it decides whether to return stored bytes, a status byte or an identification byte. A small internal byte array holds the contents.

An erase in progress can be paused. The pause takes effect only after a fixed number of cycles. While paused, the sectors not being erased can still be read and programmed, and reads in the sectors being erased return status. A resume command continues the erase from the point where it stopped. As a result, the total number of active erase cycles does not depend on how often the erase was paused.

Commands use `cmd_op` codes 0 no-op, 1 erase, 2 pause, 3 resume, 4 program, 5 identify. The sector of an address is its top `SECT_W` bits. An erase command selects sectors through the bit mask in `cmd_data[NSECT-1:0]`.

Top module: `flash_erase_ctrl`

## Requirements
- R1: An erase command accepted while idle with a nonzero mask holds `busy` high for exactly `ERASE_CYC` cycles. Afterwards every byte of the selected sectors reads 0xFF, and bytes in other sectors are unchanged. An erase command with an all-zero mask is ignored.
- R2: A pause command during an active erase keeps `busy` high for exactly `SUSP_LAT` further cycles, counted from the cycle after the command is accepted. After that, `busy` goes low and the engine is paused.
- R3: Paused cycles do not count toward the erase. The sum of erase-busy cycles over any sequence of pauses and resumes equals `ERASE_CYC`.
- R4: While paused, a read in a selected sector returns 0x80. A read in any other sector returns the stored byte.
- R5: While paused, a program to an unselected sector is accepted. `busy` is high for `PROG_CYC` cycles, and then the engine returns to the paused state with the byte updated. A program to a selected sector while paused is ignored and leaves `busy` low.
- R6: An identify command while idle makes the next read return `ID_BYTE`, and reads after that return stored data. An identify command while paused is ignored.
- R7: A resume command while paused continues the erase, whatever its address. A resume command while erasing has no effect on when the erase ends.
- R8: After a resume, a new pause command is accepted and again takes effect after `SUSP_LAT` cycles.
- R9: A pause command while no erase is running is ignored: `busy` stays low and reads return stored data.
- R10: While an erase is active and not yet paused, a read at any address returns 0x00.
- R11: After reset, `busy` is low, `rd_data` is 0x00 and every byte of the array reads 0xFF.
- R12: A program stores the old byte AND the new data and holds `busy` for `PROG_CYC` cycles. During those cycles, reads return 0x80 when bit 7 of the programmed data is 0, and 0x00 when it is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command strobe |
| cmd_op | input | 3 | Command code |
| cmd_addr | input | ADDR_W | Command byte address |
| cmd_data | input | 8 | Program data, or sector mask for erase |
| rd_en | input | 1 | Read strobe |
| rd_addr | input | ADDR_W | Read byte address |
| rd_data | output | 8 | Registered read result |
| busy | output | 1 | Erase or program engine running |

## Verification
A command changes the state at the clock edge that samples it, so `busy` is checked one sample after the command edge. A read result appears in `rd_data` at the same edge that samples `rd_en`, and the bench samples it 1 ns after that edge. The erase and program durations are counted on falling edges by a `busy` counter that is cleared just before each command. The counter is then compared with `ERASE_CYC`, `ERASE_CYC + PROG_CYC` or `PROG_CYC`. The pause latency is measured as the number of samples after the pause command edge that still show `busy`, and it must equal `SUSP_LAT`.

// File: rtl/fesc_pkg.sv
package fesc_pkg;

    typedef enum logic [2:0] {
        OP_NOP     = 3'd0,
        OP_ERASE   = 3'd1,
        OP_SUSPEND = 3'd2,
        OP_RESUME  = 3'd3,
        OP_PROGRAM = 3'd4,
        OP_AUTOSEL = 3'd5
    } op_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PROG,
        ST_ERASE,
        ST_SUSP_PEND,
        ST_SUSPENDED
    } state_e;

    typedef struct packed {
        logic       from_susp;
        logic [7:0] data;
    } prog_job_t;

    localparam logic [7:0] STAT_ERASING   = 8'h00;
    localparam logic [7:0] STAT_SUSPENDED = 8'h80;
    localparam logic [7:0] ERASED_BYTE    = 8'hFF;

    function automatic logic [7:0] prog_status(input logic [7:0] d);
        return {~d[7], 7'b0};
    endfunction

endpackage

// File: rtl/fesc_countdown.sv
module fesc_countdown #(
    parameter int W    = 8,
    parameter int INIT = 10
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic         run,
    output logic         expire,
    output logic [W-1:0] count
);
    localparam logic [W-1:0] ONE = W'(1);

    assign expire = run && !load && (count == ONE);

    always_ff @(posedge clk) begin
        if (rst) begin
            count <= '0;
        end else if (load) begin
            count <= W'(INIT);
        end else if (run && count != '0) begin
            count <= count - ONE;
        end
    end
endmodule

// File: rtl/fesc_array.sv
module fesc_array
    import fesc_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int SECT_W = 2
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   wr_en,
    input  logic [ADDR_W-1:0]      wr_addr,
    input  logic [7:0]             wr_data,
    input  logic                   fill_en,
    input  logic [(1<<SECT_W)-1:0] fill_mask,
    input  logic [ADDR_W-1:0]      rd_addr,
    output logic [7:0]             rd_byte
);
    localparam int NBYTES = 1 << ADDR_W;
    localparam int BYTE_W = ADDR_W - SECT_W;

    logic [7:0]        mem [NBYTES];
    logic [NBYTES-1:0] byte_fill;

    for (genvar g = 0; g < NBYTES; g++) begin : g_fill
        localparam logic [ADDR_W-1:0] GA = ADDR_W'(g);
        assign byte_fill[g] = fill_en && fill_mask[GA[ADDR_W-1 -: SECT_W]];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NBYTES; i++) mem[i] <= ERASED_BYTE;
        end else begin
            for (int i = 0; i < NBYTES; i++) begin
                if (byte_fill[i]) begin
                    mem[i] <= ERASED_BYTE;
                end else if (wr_en && wr_addr == ADDR_W'(i)) begin
                    mem[i] <= mem[i] & wr_data;
                end
            end
        end
    end

    assign rd_byte = mem[rd_addr];

    if (BYTE_W < 1) begin : g_bad
        initial $error("sector must hold at least two bytes");
    end
endmodule

// File: rtl/flash_erase_ctrl.sv
module flash_erase_ctrl
    import fesc_pkg::*;
#(
    parameter int         ADDR_W    = 6,
    parameter int         SECT_W    = 2,
    parameter int         ERASE_CYC = 60,
    parameter int         SUSP_LAT  = 5,
    parameter int         PROG_CYC  = 4,
    parameter logic [7:0] ID_BYTE   = 8'hA7
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_valid,
    input  logic [2:0]        cmd_op,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic [7:0]        cmd_data,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [7:0]        rd_data,
    output logic              busy
);
    localparam int NSECT = 1 << SECT_W;
    localparam int EW    = $clog2(ERASE_CYC + 1);
    localparam int SW    = $clog2(SUSP_LAT + 1);
    localparam int PW    = $clog2(PROG_CYC + 1);

    state_e            st;
    logic [NSECT-1:0]  sel_mask;
    prog_job_t         job;
    logic [ADDR_W-1:0] job_addr;
    logic              id_pend;

    op_e               op;
    logic              c_erase, c_susp, c_resume, c_prog, c_auto;
    logic [SECT_W-1:0] csect, rsect;
    logic [NSECT-1:0]  cmask;
    logic              e_load, s_load, p_load;
    logic              e_done, s_done, p_done;
    logic [EW-1:0]     e_cnt;
    logic [SW-1:0]     s_cnt;
    logic [PW-1:0]     p_cnt;
    logic [7:0]        arr_byte, rd_next;

    assign op       = op_e'(cmd_op);
    assign c_erase  = cmd_valid && op == OP_ERASE;
    assign c_susp   = cmd_valid && op == OP_SUSPEND;
    assign c_resume = cmd_valid && op == OP_RESUME;
    assign c_prog   = cmd_valid && op == OP_PROGRAM;
    assign c_auto   = cmd_valid && op == OP_AUTOSEL;
    assign csect    = cmd_addr[ADDR_W-1 -: SECT_W];
    assign rsect    = rd_addr[ADDR_W-1 -: SECT_W];
    assign cmask    = cmd_data[NSECT-1:0];

    assign e_load = (st == ST_IDLE) && c_erase && (|cmask);
    assign s_load = (st == ST_ERASE) && c_susp && !e_done;
    assign p_load = c_prog && ((st == ST_IDLE) ||
                    ((st == ST_SUSPENDED) && !c_resume && !sel_mask[csect]));

    fesc_countdown #(.W(EW), .INIT(ERASE_CYC)) u_erase_tmr (
        .clk(clk), .rst(rst), .load(e_load),
        .run(st == ST_ERASE || st == ST_SUSP_PEND),
        .expire(e_done), .count(e_cnt));

    fesc_countdown #(.W(SW), .INIT(SUSP_LAT)) u_susp_tmr (
        .clk(clk), .rst(rst), .load(s_load),
        .run(st == ST_SUSP_PEND),
        .expire(s_done), .count(s_cnt));

    fesc_countdown #(.W(PW), .INIT(PROG_CYC)) u_prog_tmr (
        .clk(clk), .rst(rst), .load(p_load),
        .run(st == ST_PROG),
        .expire(p_done), .count(p_cnt));

    fesc_array #(.ADDR_W(ADDR_W), .SECT_W(SECT_W)) u_array (
        .clk(clk), .rst(rst),
        .wr_en(p_done), .wr_addr(job_addr), .wr_data(job.data),
        .fill_en(e_done), .fill_mask(sel_mask),
        .rd_addr(rd_addr), .rd_byte(arr_byte));

    always_ff @(posedge clk) begin
        if (rst) begin
            st       <= ST_IDLE;
            sel_mask <= '0;
            job      <= '0;
            job_addr <= '0;
            id_pend  <= 1'b0;
        end else begin
            if (rd_en) id_pend <= 1'b0;
            if (p_load) begin
                job.data      <= cmd_data;
                job.from_susp <= (st == ST_SUSPENDED);
                job_addr      <= cmd_addr;
            end
            case (st)
                ST_IDLE: begin
                    if (e_load) begin
                        sel_mask <= cmask;
                        id_pend  <= 1'b0;
                        st       <= ST_ERASE;
                    end else if (p_load) begin
                        id_pend  <= 1'b0;
                        st       <= ST_PROG;
                    end else if (c_auto) begin
                        id_pend  <= 1'b1;
                    end
                end
                ST_PROG: begin
                    if (p_done) st <= job.from_susp ? ST_SUSPENDED : ST_IDLE;
                end
                ST_ERASE, ST_SUSP_PEND: begin
                    if (e_done) begin
                        sel_mask <= '0;
                        st       <= ST_IDLE;
                    end else if (s_load) begin
                        st       <= ST_SUSP_PEND;
                    end else if (s_done) begin
                        st       <= ST_SUSPENDED;
                    end
                end
                ST_SUSPENDED: begin
                    if (c_resume)    st <= ST_ERASE;
                    else if (p_load) st <= ST_PROG;
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        case (st)
            ST_ERASE, ST_SUSP_PEND: rd_next = STAT_ERASING;
            ST_PROG:                rd_next = prog_status(job.data);
            ST_SUSPENDED:           rd_next = sel_mask[rsect] ? STAT_SUSPENDED : arr_byte;
            default:                rd_next = id_pend ? ID_BYTE : arr_byte;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)        rd_data <= 8'h00;
        else if (rd_en) rd_data <= rd_next;
    end

    assign busy = (st == ST_PROG) || (st == ST_ERASE) || (st == ST_SUSP_PEND);

    p_erase_live_r1: assert property (@(posedge clk) disable iff (rst)
        (st == ST_ERASE) |-> (e_cnt != '0));
    p_susp_bound_r2: assert property (@(posedge clk) disable iff (rst)
        (st == ST_SUSP_PEND) |-> (s_cnt != '0));
    p_hold_count_r3: assert property (@(posedge clk) disable iff (rst)
        (st == ST_SUSPENDED) |=> (e_cnt == $past(e_cnt)));
    p_sel_status_r4: assert property (@(posedge clk) disable iff (rst)
        (st == ST_SUSPENDED && rd_en && sel_mask[rsect]) |=> (rd_data == STAT_SUSPENDED));
    p_prog_return_r5: assert property (@(posedge clk) disable iff (rst)
        (st == ST_PROG && p_done && job.from_susp) |=> (st == ST_SUSPENDED && !busy));
    p_prog_live_r12: assert property (@(posedge clk) disable iff (rst)
        (st == ST_PROG) |-> (p_cnt != '0));
    p_auto_ignored_r6: assert property (@(posedge clk) disable iff (rst)
        (st == ST_SUSPENDED && c_auto) |=> !id_pend);
    p_resume_r7: assert property (@(posedge clk) disable iff (rst)
        (st == ST_SUSPENDED && c_resume) |=> (st == ST_ERASE && busy));
    p_idle_susp_r9: assert property (@(posedge clk) disable iff (rst)
        (st == ST_IDLE && c_susp) |=> (st == ST_IDLE && !busy));
endmodule

// File: tb/flash_erase_ctrl_bench.sv
module flash_erase_ctrl_bench;
    localparam int         ADDR_W    = 6;
    localparam int         SECT_W    = 2;
    localparam int         ERASE_CYC = 60;
    localparam int         SUSP_LAT  = 5;
    localparam int         PROG_CYC  = 4;
    localparam logic [7:0] ID_BYTE   = 8'hA7;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              cmd_valid = 1'b0;
    logic [2:0]        cmd_op = 3'd0;
    logic [ADDR_W-1:0] cmd_addr = '0;
    logic [7:0]        cmd_data = 8'h00;
    logic              rd_en = 1'b0;
    logic [ADDR_W-1:0] rd_addr = '0;
    logic [7:0]        rd_data;
    logic              busy;

    int checks = 0;
    int fails  = 0;
    int busy_cnt = 0;

    flash_erase_ctrl #(
        .ADDR_W(ADDR_W), .SECT_W(SECT_W), .ERASE_CYC(ERASE_CYC),
        .SUSP_LAT(SUSP_LAT), .PROG_CYC(PROG_CYC), .ID_BYTE(ID_BYTE)
    ) u_flash_erase_ctrl (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_addr(cmd_addr), .cmd_data(cmd_data), .rd_en(rd_en),
        .rd_addr(rd_addr), .rd_data(rd_data), .busy(busy));

    always #2 clk = ~clk;

    always @(negedge clk) if (busy) busy_cnt++;

    task automatic cyc();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic send(input logic [2:0] op, input int addr, input logic [7:0] data);
        cmd_valid = 1'b1;
        cmd_op    = op;
        cmd_addr  = ADDR_W'(addr);
        cmd_data  = data;
        cyc();
        cmd_valid = 1'b0;
        cmd_op    = 3'd0;
    endtask

    task automatic rd(input int addr, output logic [7:0] d);
        rd_en   = 1'b1;
        rd_addr = ADDR_W'(addr);
        cyc();
        d       = rd_data;
        rd_en   = 1'b0;
    endtask

    task automatic wait_idle(output int n);
        n = 0;
        while (busy && n < 5000) begin
            n++;
            cyc();
        end
    endtask

    task automatic expect_rd(input string req, input int addr, input logic [7:0] exp);
        logic [7:0] d;
        rd(addr, d);
        chk(req, d, exp);
    endtask

    task automatic t_reset();
        chk("R11 busy", busy, 0);
        chk("R11 rd_data", rd_data, 8'h00);
        expect_rd("R11 byte0", 0, 8'hFF);
        expect_rd("R11 byte63", 63, 8'hFF);
    endtask

    task automatic t_idle_program();
        int n;
        busy_cnt = 0;
        send(3'd4, 5, 8'h3C);
        expect_rd("R12 status", 17, 8'h80);
        wait_idle(n);
        chk("R12 busy cycles", busy_cnt, PROG_CYC);
        expect_rd("R12 stored", 5, 8'h3C);
        send(3'd4, 5, 8'hF0);
        expect_rd("R12 status bit7 set", 5, 8'h00);
        wait_idle(n);
        expect_rd("R12 and", 5, 8'h30);
        send(3'd4, 40, 8'h11);
        wait_idle(n);
        send(3'd4, 20, 8'h22);
        wait_idle(n);
        expect_rd("R12 sector2", 40, 8'h11);
    endtask

    task automatic t_autoselect_idle();
        send(3'd5, 0, 8'h00);
        expect_rd("R6 id", 0, ID_BYTE);
        expect_rd("R6 after id", 0, 8'hFF);
    endtask

    task automatic t_suspend_idle();
        send(3'd2, 5, 8'h00);
        chk("R9 busy", busy, 0);
        expect_rd("R9 data", 5, 8'h30);
    endtask

    task automatic t_plain_erase();
        int n;
        send(3'd1, 0, 8'h00);
        chk("R1 zero mask ignored", busy, 0);
        busy_cnt = 0;
        send(3'd1, 0, 8'h01);
        chk("R1 busy", busy, 1);
        expect_rd("R10 other sector", 20, 8'h00);
        expect_rd("R10 selected", 5, 8'h00);
        wait_idle(n);
        chk("R1 erase cycles", busy_cnt, ERASE_CYC);
        expect_rd("R1 erased", 5, 8'hFF);
        expect_rd("R1 kept s1", 20, 8'h22);
        expect_rd("R1 kept s2", 40, 8'h11);
    endtask

    task automatic t_suspend_resume();
        int n;
        send(3'd4, 5, 8'h0F);
        wait_idle(n);
        busy_cnt = 0;
        send(3'd1, 0, 8'h05);
        repeat (10) cyc();
        send(3'd2, 0, 8'h00);
        wait_idle(n);
        chk("R2 latency", n, SUSP_LAT);
        expect_rd("R4 sel s0", 5, 8'h80);
        expect_rd("R4 sel s2", 45, 8'h80);
        expect_rd("R4 unsel", 20, 8'h22);
        send(3'd5, 0, 8'h00);
        expect_rd("R6 ignored in pause", 20, 8'h22);
        send(3'd4, 30, 8'h5A);
        wait_idle(n);
        chk("R5 prog cycles", n, PROG_CYC);
        expect_rd("R5 stored", 30, 8'h5A);
        expect_rd("R5 still paused", 5, 8'h80);
        send(3'd4, 6, 8'h00);
        chk("R5 sel prog ignored", busy, 0);
        repeat (5) cyc();
        send(3'd3, 63, 8'h00);
        chk("R7 resume", busy, 1);
        repeat (5) cyc();
        send(3'd2, 0, 8'h00);
        wait_idle(n);
        chk("R8 second pause", n, SUSP_LAT);
        expect_rd("R8 paused status", 45, 8'h80);
        send(3'd3, 0, 8'h00);
        repeat (3) cyc();
        send(3'd3, 0, 8'h00);
        chk("R7 extra resume", busy, 1);
        wait_idle(n);
        chk("R3 total cycles", busy_cnt, ERASE_CYC + PROG_CYC);
        expect_rd("R1 s0 erased", 5, 8'hFF);
        expect_rd("R1 s2 erased", 40, 8'hFF);
        expect_rd("R5 kept s1", 30, 8'h5A);
        expect_rd("R1 kept s1", 20, 8'h22);
    endtask

    initial begin
        #400000;
        fails++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (3) cyc();
        rst = 1'b0;
        t_reset();
        t_idle_program();
        t_autoselect_idle();
        t_suspend_idle();
        t_plain_erase();
        t_suspend_resume();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule